// File: doc/BRIEF.md
# Multi-level interrupt acceptance controller

This block decides whether a pending interrupt request goes on to the CPU, and which one. It takes a non-maskable interrupt pin, eight wakeup pins and a parameterised set of other maskable request lines. Each pin input passes through a two-stage synchronizer and an edge detector. A detected edge on the non-maskable pin sets a pending latch. A detected edge on a wakeup pin sets that pin's flag bit. The CPU can read the flags and clear them over a small byte-wide register bus.

Acceptance is graded. A global disable input blocks every maskable source. A 2-bit mask field blocks sources by their mask level: wakeup flags share one level, set by a parameter, and each other line brings its own level on a port. A shared wakeup enable gates all eight flags. The non-maskable request ignores all of these gates.

The accepted requests go to a fixed-priority picker. The request and the vector number of the winner are registered on the way out.

Top module: `intr_accept_ctrl`

## Requirements
- R1: The mask register at bus address 0 reads with bits 7..2 always 1 and ignores writes to them. Bits 1..0 hold the mask field, are writable, and reset to 0, so the reset readback is 0xFC.
- R2: Each source has a 2-bit mask level. Mask field 2 or 3 blocks sources of level 0 and 1. Mask field 1 blocks only level 0. Mask field 0 blocks nothing. Wakeup flags use the level parameter, which defaults to 1.
- R3: A pending non-maskable request always produces irq=1 with vec=0, even when the global disable is 1 or the mask field is 3.
- R4: Control register (address 4) bit 0 selects the non-maskable edge: 1 = rising, 0 = falling (the reset value). An edge of the other direction sets nothing.
- R5: Wakeup flag i (address 1, bit i) is set by an edge on wakeup pin i only while pin-mode bit i (address 2) is 1. Polarity bit i (address 3) selects the edge: 1 = rising, 0 = falling.
- R6: While control bit 1 (the shared wakeup enable) is 0, no wakeup flag produces a request.
- R7: While the global disable input is 1, no maskable source produces a request.
- R8: A wakeup flag is cleared by writing 0 to its bit at address 1. Writing 1 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the flag stays set.
- R9: Among accepted requests the lowest vector wins. The non-maskable request is vector 0, wakeup flag i is vector 1+i, and other line j is vector 9+j.
- R10: A one-cycle nmi_ack pulse clears the non-maskable pending latch. irq is registered and falls one cycle after the last accepted source goes away.
- R11: A pin change that settles before clock edge k shows in the flag or pending state after edge k+2, and on irq/vec after edge k+3. A change on a maskable input or register reaches irq/vec after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| wake_pins | input | 8 | Wakeup pins, asynchronous |
| gdis | input | 1 | Global interrupt disable for maskable sources |
| other_req | input | N_OTHER | Other maskable request lines, level-held |
| other_lvl | input | 2*N_OTHER | Mask level of each other line, 2 bits each |
| nmi_ack | input | 1 | One-cycle acknowledge of the non-maskable request |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Registered interrupt request to the CPU |
| vec | output | VEC_W | Registered vector number of the winning source |

## Verification
Results come back at fixed depths:
- A pin edge shows in the flag readback three edges after the pin changes, and on irq/vec one edge after that.
- A bus write, a mask-level input or a global-disable change shows on irq/vec after one edge.
- An acknowledge drops irq two edges after it is raised.

The bench drives all inputs on the falling edge and waits exactly that many rising edges before each sample. The sample is taken 1 ns after the rising edge. This means an off-by-one stage in the design shows up as a mismatch. The random part varies the global disable, the mask field, the request lines and their levels against a bench model of acceptance and priority.

// File: rtl/intr_pkg.sv
// Package: register addresses and the level-acceptance rule shared by the
// controller. Assumes a 3-bit register address space.
package intr_pkg;
    localparam int          ADDR_W = 3;
    localparam logic [2:0]  A_MASK = 3'd0;
    localparam logic [2:0]  A_FLAG = 3'd1;
    localparam logic [2:0]  A_PMOD = 3'd2;
    localparam logic [2:0]  A_POL  = 3'd3;
    localparam logic [2:0]  A_CTRL = 3'd4;

    // True when a source of level lvl gets through mask field msk.
    function automatic logic lvl_pass(input logic [1:0] lvl, input logic [1:0] msk);
        if (msk[1])
            return lvl > 2'd1;
        else if (msk[0])
            return lvl != 2'd0;
        else
            return 1'b1;
    endfunction
endpackage

// File: rtl/intr_sync_edge.sv
// Two-flop synchronizer plus an edge detector per bit. pol=1 selects the
// rising edge, pol=0 the falling edge. hit is combinational from the flops
// and is high for one cycle. Assumes the pins are asynchronous to clk.
module intr_sync_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2, s3;
        // Synchronize the pin and keep the previous synchronized value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= pin[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign hit[g] = pol[g] ? (s2 & ~s3) : (~s2 & s3);
    end
endmodule

// File: rtl/intr_wake_flags.sv
// Wakeup flag register. An edge sets a flag only while its pin-mode bit is
// 1. A write clears the bits written as 0, and a same-cycle edge wins over
// the clear. Writing 1 never sets a flag.
module intr_wake_flags #(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] hit,
    input  logic [NW-1:0] pin_en,
    input  logic          clr_wr,
    input  logic [NW-1:0] wdata,
    output logic [NW-1:0] flags
);
    logic [NW-1:0] kept;
    // Keep a flag unless a write gives a 0 for its bit.
    always_comb kept = clr_wr ? (flags & wdata) : flags;

    // Update the flags; a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= kept | (hit & pin_en);
    end
endmodule

// File: rtl/intr_prio_pick.sv
// Fixed-priority picker: the lowest set index wins. idx is 0 when nothing
// is set.
module intr_prio_pick #(
    parameter int N  = 13,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  acc,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set index is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (acc[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intr_accept_ctrl.sv
// Multi-level interrupt acceptance controller. It synchronizes and
// edge-detects the non-maskable pin and the wakeup pins, holds the flag,
// mask, pin-mode, polarity and control registers, gates each maskable
// source by the global disable and the mask level, and registers the
// fixed-priority winner as irq/vec.
// Assumes other_req is a synchronous, level-held input.
module intr_accept_ctrl #(
    parameter int         NWAKE    = 8,
    parameter int         N_OTHER  = 4,
    parameter logic [1:0] WAKE_LVL = 2'd1,
    localparam int        NSRC     = 1 + NWAKE + N_OTHER,
    localparam int        VEC_W    = $clog2(NSRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_pin,
    input  logic [NWAKE-1:0]     wake_pins,
    input  logic                 gdis,
    input  logic [N_OTHER-1:0]   other_req,
    input  logic [2*N_OTHER-1:0] other_lvl,
    input  logic                 nmi_ack,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 irq,
    output logic [VEC_W-1:0]     vec
);
    import intr_pkg::*;

    logic [1:0]       msk;
    logic [NWAKE-1:0] pmode, pol, flags, whit;
    logic             nmi_rise, wake_en, nmi_hit, nmi_pend;
    logic [NSRC-1:0]  acc;
    logic             any;
    logic [VEC_W-1:0] win;

    // Software-writable registers: mask field, pin mode, polarity, control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk      <= 2'b00;
            pmode    <= '0;
            pol      <= '0;
            nmi_rise <= 1'b0;
            wake_en  <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_MASK: msk   <= bus_wdata[1:0];
                A_PMOD: pmode <= bus_wdata[NWAKE-1:0];
                A_POL:  pol   <= bus_wdata[NWAKE-1:0];
                A_CTRL: begin
                    nmi_rise <= bus_wdata[0];
                    wake_en  <= bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    intr_sync_edge #(.W(1)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .pol(nmi_rise), .hit(nmi_hit)
    );

    intr_sync_edge #(.W(NWAKE)) u_wake_sync (
        .clk(clk), .rst_n(rst_n), .pin(wake_pins), .pol(pol), .hit(whit)
    );

    intr_wake_flags #(.NW(NWAKE)) u_flags (
        .clk(clk), .rst_n(rst_n), .hit(whit), .pin_en(pmode),
        .clr_wr(bus_wr && bus_addr == A_FLAG), .wdata(bus_wdata[NWAKE-1:0]),
        .flags(flags)
    );

    // Non-maskable pending latch: an edge sets it, an acknowledge clears it, and a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pend <= 1'b0;
        else        nmi_pend <= nmi_hit | (nmi_pend & ~nmi_ack);
    end

    // Build the accepted-request vector in priority order.
    always_comb begin
        acc[0] = nmi_pend;
        for (int i = 0; i < NWAKE; i++)
            acc[1 + i] = flags[i] & wake_en & ~gdis & lvl_pass(WAKE_LVL, msk);
        for (int j = 0; j < N_OTHER; j++)
            acc[1 + NWAKE + j] = other_req[j] & ~gdis & lvl_pass(other_lvl[2*j +: 2], msk);
    end

    intr_prio_pick #(.N(NSRC), .IW(VEC_W)) u_pick (
        .acc(acc), .any(any), .idx(win)
    );

    // Register the request and the vector of the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            vec <= '0;
        end else begin
            irq <= any;
            vec <= win;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            A_MASK:  bus_rdata = {6'h3f, msk};
            A_FLAG:  bus_rdata = 8'(flags);
            A_PMOD:  bus_rdata = 8'(pmode);
            A_POL:   bus_rdata = 8'(pol);
            A_CTRL:  bus_rdata = {6'h00, wake_en, nmi_rise};
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/intr_accept_chk.sv
// Assertion checker for intr_accept_ctrl, attached with bind. It watches
// ports and internal state only and drives nothing.
module intr_accept_chk #(
    parameter int NWAKE   = 8,
    parameter int N_OTHER = 4,
    parameter int VEC_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gdis,
    input logic               nmi_ack,
    input logic               wake_en,
    input logic [N_OTHER-1:0] other_req,
    input logic [2:0]         bus_addr,
    input logic               bus_wr,
    input logic [7:0]         bus_rdata,
    input logic               irq,
    input logic [VEC_W-1:0]   vec,
    input logic               nmi_pend,
    input logic [NWAKE-1:0]   flags,
    input logic [NWAKE-1:0]   pmode
);
    // R1
    mask_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> (bus_rdata[7:2] == 6'h3f));
    // R3
    nmi_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |=> (irq && vec == '0));
    // R7
    gdis_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gdis && !nmi_pend) |=> !irq);
    // R6
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_en && !nmi_pend && other_req == '0) |=> !irq);
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(pmode)) == '0));
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd1) |=> ((~flags & $past(flags)) == '0));
    // R10
    nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_pend) |-> $past(nmi_ack));
endmodule

bind intr_accept_ctrl intr_accept_chk #(
    .NWAKE(NWAKE), .N_OTHER(N_OTHER), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .gdis(gdis), .nmi_ack(nmi_ack), .wake_en(wake_en),
    .other_req(other_req), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .irq(irq), .vec(vec), .nmi_pend(nmi_pend),
    .flags(flags), .pmode(pmode)
);

// File: tb/sim_intr_accept_ctrl.sv
`timescale 1ns/1ps
module sim_intr_accept_ctrl;
    localparam int NO = 4;
    logic clk = 1'b0, rst_n = 1'b0;
    logic nmi_pin = 1'b0;
    logic [7:0] wake_pins = '0;
    logic gdis = 1'b0;
    logic [NO-1:0] other_req = '0;
    logic [2*NO-1:0] other_lvl = '0;
    logic nmi_ack = 1'b0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq;
    logic [3:0] vec;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intr_accept_ctrl #(.NWAKE(8), .N_OTHER(NO), .WAKE_LVL(2'd1)) u0 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .wake_pins(wake_pins),
        .gdis(gdis), .other_req(other_req), .other_lvl(other_lvl),
        .nmi_ack(nmi_ack), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .vec(vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #0.5;
        d = bus_rdata;
    endtask

    // Bench model: the expected irq and vec from the other lines alone.
    function automatic int exp_vec(input logic g, input logic [1:0] m,
                                   input logic [NO-1:0] rq, input logic [2*NO-1:0] lv);
        int need;
        need = (m >= 2) ? 2 : ((m == 1) ? 1 : 0);
        for (int j = 0; j < NO; j++)
            if (!g && rq[j] && int'(lv[2*j +: 2]) >= need) return 9 + j;
        return -1;
    endfunction

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(1);
        // R1: reset state
        rd(3'd0, d); chk("R1 reset mask", d, 8'hFC);
        rd(3'd1, d); chk("R8 reset flags", d, 0);
        chk("R10 reset irq", irq, 0);
        wr(3'd0, 8'h01); rd(3'd0, d); chk("R1 mask write 01", d, 8'hFD);
        wr(3'd0, 8'h03); rd(3'd0, d); chk("R1 mask write 03", d, 8'hFF);
        wr(3'd0, 8'h00); rd(3'd0, d); chk("R1 mask write 00", d, 8'hFC);

        // R5: an edge with the pin mode off sets nothing
        wr(3'd4, 8'h02);
        wr(3'd3, 8'hFF);
        @(negedge clk) wake_pins[5] = 1'b1;
        bus_addr = 3'd1;
        tick(5); rd(3'd1, d); chk("R5 pin mode off", d, 0);
        wr(3'd2, 8'hFF);
        @(negedge clk) wake_pins[5] = 1'b0;
        tick(5); rd(3'd1, d); chk("R5 falling ignored when rising selected", d, 0);
        // R11: flag after three edges, irq one edge later
        @(negedge clk) wake_pins[5] = 1'b1;
        bus_addr = 3'd1;
        tick(2); chk("R11 flag not early", bus_rdata, 0);
        tick(1); chk("R11 R5 flag after 3 edges", bus_rdata, 8'h20);
        chk("R11 irq not early", irq, 0);
        tick(1); chk("R11 irq after 4 edges", irq, 1);
        chk("R9 vec wake5", vec, 6);
        // R6: the shared enable off gates the flags
        wr(3'd4, 8'h00); tick(1); chk("R6 wake enable off", irq, 0);
        wr(3'd4, 8'h02); tick(1); chk("R6 wake enable on", irq, 1);
        // R7: global disable
        @(negedge clk) gdis = 1'b1; tick(1); chk("R7 gdis blocks wake", irq, 0);
        @(negedge clk) gdis = 1'b0;
        // R2: wake level 1 blocked by mask field 2
        wr(3'd0, 8'h02); tick(1); chk("R2 mask 2 blocks lvl1", irq, 0);
        wr(3'd0, 8'h01); tick(1); chk("R2 mask 1 passes lvl1", irq, 1);
        wr(3'd0, 8'h00);
        // R8: writing 1 keeps the flag, writing 0 clears it, irq falls one edge later
        wr(3'd1, 8'hFF); rd(3'd1, d); chk("R8 write 1 keeps flag", d, 8'h20);
        wr(3'd1, 8'h00); rd(3'd1, d); chk("R8 write 0 clears", d, 0);
        chk("R10 irq still up at clear edge", irq, 1);
        tick(1); chk("R10 irq falls next edge", irq, 0);
        // R8: an edge in the same cycle as the clear wins
        @(negedge clk) wake_pins[2] = 1'b1;
        tick(4); rd(3'd1, d); chk("R8 flag2 set", d, 8'h04);
        @(negedge clk) wake_pins[2] = 1'b0;
        tick(4);
        @(negedge clk) wake_pins[2] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        bus_addr = 3'd1; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
        rd(3'd1, d); chk("R8 edge wins over clear", d, 8'h04);
        wr(3'd1, 8'h00); tick(1);

        // R9: priority among wake flags and the other lines
        @(negedge clk) begin wake_pins[0] = 1'b1; wake_pins[3] = 1'b1;
            other_req = 4'b0001; other_lvl = 8'h03; end
        tick(4); chk("R9 wake0 first", vec, 1);
        wr(3'd1, 8'hFE); tick(1); chk("R9 wake3 next", vec, 4);
        wr(3'd1, 8'h00); tick(1); chk("R9 other0 last", vec, 9);

        // R3 R4: rising select, bypass of gdis and mask 3
        wr(3'd4, 8'h03); wr(3'd0, 8'h03);
        @(negedge clk) begin gdis = 1'b1; nmi_pin = 1'b1; end
        tick(4); chk("R3 R4 nmi rising accepted", irq, 1);
        chk("R3 nmi vec 0", vec, 0);
        @(negedge clk) nmi_ack = 1'b1;
        @(posedge clk); #1 nmi_ack = 1'b0;
        chk("R10 irq held at ack edge", irq, 1);
        tick(1); chk("R10 ack drops irq", irq, 0);
        wr(3'd4, 8'h02);
        @(negedge clk) nmi_pin = 1'b0;
        tick(4); chk("R4 nmi falling accepted", irq, 1);
        @(negedge clk) nmi_ack = 1'b1;
        @(posedge clk); #1 nmi_ack = 1'b0;
        tick(1);
        @(negedge clk) nmi_pin = 1'b1;
        tick(5); chk("R4 rising ignored when falling selected", irq, 0);

        // R2 R7 R9: random acceptance against the bench model
        wr(3'd2, 8'h00);
        for (int k = 0; k < 300; k++) begin
            logic [1:0] m;
            int e;
            m = 2'($urandom);
            wr(3'd0, {6'h0, m});
            @(negedge clk);
            gdis = ($urandom % 4) == 0;
            other_req = NO'($urandom);
            other_lvl = 8'($urandom);
            tick(1);
            e = exp_vec(gdis, m, other_req, other_lvl);
            chk("R2 R7 random irq", irq, (e >= 0) ? 1 : 0);
            if (e >= 0) chk("R9 random vec", vec, e);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule